// File: doc/BRIEF.md
# FEC Error Statistics Counter Bank

This block gathers error statistics produced by a forward-error-correction decoder. It has nine accumulators. Each one adds a small increment value every clock cycle. The increment lanes are packed into one input bus, and lane `i` occupies bits `[i*INC_W +: INC_W]`.

The lanes carry these statistics, in this order:

| Lane | Statistic |
|------|-----------|
| 0 | Total corrected bits |
| 1 | Bits corrected to zero |
| 2 | Bits corrected to one |
| 3 | Uncorrectable codewords |
| 4 | Corrupted symbols |
| 5 | Late-transition pattern errors |
| 6 | Early-transition pattern errors |
| 7 | Isolated-bit errors with opposite neighbours |
| 8 | Isolated-bit errors with equal neighbours |

A periodic snapshot strobe arrives, typically once per second. On that strobe, every accumulator is copied into its own cache register in a single cycle. Software never sees the live accumulators. It reads the cache through a simple port, one half-word at a time.

A mode input selects what happens to the accumulators at each snapshot:
- **Clear mode:** each accumulator restarts from zero after the snapshot.
- **Retain mode:** each accumulator keeps counting, and it saturates at all ones instead of wrapping.

Reading an upper half also captures the matching lower half in a holding register. As a result, an upper-then-lower read pair always returns one coherent value, even if a snapshot occurs between the two reads.

Top module: `fec_stat_bank`

## Requirements
- R1: While `rst_n` is low, all accumulators, cache registers, the holding register and `rd_data` are zero, and `rd_valid` is low.
- R2: When there is no snapshot strobe, each accumulator adds its lane's increment every cycle, and the cache registers keep their value.
- R3: In a cycle with `snap_tick` high, each cache register takes the accumulator value from before that cycle's increment.
- R4: With `clear_on_snap` = 1, the accumulator value after a snapshot equals only the increment that arrived in the snapshot cycle. Between snapshots it wraps modulo 2^CNT_W.
- R5: With `clear_on_snap` = 0, a snapshot leaves the accumulator running: its value after the snapshot is the prior value plus that cycle's increment. No increment is lost.
- R6: With `clear_on_snap` = 0, an accumulator saturates at all ones and never wraps.
- R7: `rd_valid` rises exactly one cycle after `rd_en`. When `rd_addr[0]` = 1, `rd_data` returns the upper `CNT_W/2` bits of the cache register selected by `rd_addr[ADDR_W-1:1]`. A counter index of 9 or more reads as zero.
- R8: A read with `rd_addr[0]` = 1 loads the lower half of the selected cache register into the holding register. A read with `rd_addr[0]` = 0 returns the holding register whatever its index, and later snapshots do not alter the holding register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_on_snap | input | 1 | 1: clear at snapshot; 0: retain and saturate |
| snap_tick | input | 1 | Single-cycle snapshot strobe |
| inc_i | input | NUM_CNT*INC_W | Packed per-cycle increments, lane `i` at `[i*INC_W +: INC_W]` |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | `{counter index, half}`; half 1 = upper, 0 = lower |
| rd_data | output | CNT_W/2 | Read half-word, registered |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |

## Verification
The hardest state to reach from the ports is saturation, because a 32-bit counter cannot be filled within a short run. The bench therefore builds the bank with a 16-bit counter width and drives full-scale increments on all lanes for several hundred cycles. This makes every lane hit all ones, and the same stimulus is then repeated in clear mode to check wrapping. The stimulus also covers two timing cases: a snapshot that coincides with non-zero increments, and a snapshot placed between the two halves of a paired read.

// File: rtl/fec_stat_pkg.sv
package fec_stat_pkg;

    // Default geometry of the counter bank
    localparam int DEF_NUM_CNT = 9;
    localparam int DEF_CNT_W   = 32;
    localparam int DEF_INC_W   = 7;

    // Half selector carried in the lowest address bit
    typedef enum logic {
        HALF_LOWER = 1'b0,
        HALF_UPPER = 1'b1
    } half_sel_e;

endpackage

// File: rtl/fec_stat_acc.sv
module fec_stat_acc #(
    parameter int CNT_W = 32,
    parameter int INC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_mode,
    input  logic             snap,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] acc
);

    typedef struct packed {
        logic [CNT_W-1:0] acc;
    } acc_st_t;

    acc_st_t        st_d, st_q;
    logic [CNT_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.acc} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
        if (clear_mode) begin
            // wrap between snapshots; restart from this cycle's increment
            if (snap) begin
                st_d.acc = {{(CNT_W - INC_W){1'b0}}, inc};
            end else begin
                st_d.acc = sum[CNT_W-1:0];
            end
        end else begin
            // keep counting across the snapshot, stop at all ones
            if (sum[CNT_W]) begin
                st_d.acc = '1;
            end else begin
                st_d.acc = sum[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;

endmodule

// File: rtl/fec_stat_cache.sv
module fec_stat_cache #(
    parameter int NUM_CNT = 9,
    parameter int CNT_W   = 32,
    localparam int FLAT_W = NUM_CNT * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap,
    input  logic [FLAT_W-1:0] acc_flat,
    output logic [FLAT_W-1:0] cache_flat
);

    typedef struct packed {
        logic [FLAT_W-1:0] img;
    } cache_st_t;

    cache_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (snap) begin
            st_d.img = acc_flat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cache_flat = st_q.img;

endmodule

// File: rtl/fec_stat_rdport.sv
module fec_stat_rdport
    import fec_stat_pkg::*;
#(
    parameter int NUM_CNT = 9,
    parameter int CNT_W   = 32,
    localparam int IDX_W  = $clog2(NUM_CNT),
    localparam int ADDR_W = IDX_W + 1,
    localparam int HALF_W = CNT_W / 2,
    localparam int FLAT_W = NUM_CNT * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [FLAT_W-1:0] cache_flat,
    output logic [HALF_W-1:0] rd_data,
    output logic              rd_valid
);

    typedef struct packed {
        logic [HALF_W-1:0] data;
        logic [HALF_W-1:0] hold;
        logic              valid;
    } rd_st_t;

    rd_st_t           st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] sel;
    half_sel_e        half;

    assign idx  = rd_addr[ADDR_W-1:1];
    assign half = half_sel_e'(rd_addr[0]);

    // counter select; an index past the bank reads zero
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (idx == IDX_W'(i)) begin
                sel = cache_flat[i*CNT_W +: CNT_W];
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_en;
        if (rd_en) begin
            if (half == HALF_UPPER) begin
                st_d.data = sel[CNT_W-1:HALF_W];
                st_d.hold = sel[HALF_W-1:0];
            end else begin
                st_d.data = st_q.hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.data;
    assign rd_valid = st_q.valid;

endmodule

// File: rtl/fec_stat_bank.sv
module fec_stat_bank
    import fec_stat_pkg::*;
#(
    parameter int NUM_CNT = DEF_NUM_CNT,
    parameter int CNT_W   = DEF_CNT_W,
    parameter int INC_W   = DEF_INC_W,
    localparam int IDX_W  = $clog2(NUM_CNT),
    localparam int ADDR_W = IDX_W + 1,
    localparam int HALF_W = CNT_W / 2,
    localparam int IN_W   = NUM_CNT * INC_W,
    localparam int FLAT_W = NUM_CNT * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_on_snap,
    input  logic              snap_tick,
    input  logic [IN_W-1:0]   inc_i,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [HALF_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [FLAT_W-1:0] acc_flat;
    logic [FLAT_W-1:0] cache_flat;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
        fec_stat_acc #(
            .CNT_W (CNT_W),
            .INC_W (INC_W)
        ) u_acc (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear_mode (clear_on_snap),
            .snap       (snap_tick),
            .inc        (inc_i[g*INC_W +: INC_W]),
            .acc        (acc_flat[g*CNT_W +: CNT_W])
        );
    end

    fec_stat_cache #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W)
    ) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .snap       (snap_tick),
        .acc_flat   (acc_flat),
        .cache_flat (cache_flat)
    );

    fec_stat_rdport #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .cache_flat (cache_flat),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

endmodule

// File: rtl/fec_stat_bank_chk.sv
module fec_stat_bank_chk #(
    parameter int NUM_CNT = 9,
    parameter int CNT_W   = 32,
    parameter int INC_W   = 7,
    localparam int IN_W   = NUM_CNT * INC_W,
    localparam int FLAT_W = NUM_CNT * CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_on_snap,
    input logic              snap_tick,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [IN_W-1:0]   inc_i,
    input logic [FLAT_W-1:0] acc_flat,
    input logic [FLAT_W-1:0] cache_flat
);

    // R7
    rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R7
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R2
    cache_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_tick |=> $stable(cache_flat));

    // R3
    snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_tick |=> cache_flat == $past(acc_flat));

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane_chk
        // R4
        clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (snap_tick && clear_on_snap) |=>
            acc_flat[g*CNT_W +: CNT_W] ==
                {{(CNT_W - INC_W){1'b0}}, $past(inc_i[g*INC_W +: INC_W])});

        // R5
        retain_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clear_on_snap |=>
            acc_flat[g*CNT_W +: CNT_W] >= $past(acc_flat[g*CNT_W +: CNT_W]));

        // R6
        sat_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clear_on_snap && (&acc_flat[g*CNT_W +: CNT_W])) |=>
            (&acc_flat[g*CNT_W +: CNT_W]));
    end

endmodule

bind fec_stat_bank fec_stat_bank_chk #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .INC_W   (INC_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_on_snap (clear_on_snap),
    .snap_tick     (snap_tick),
    .rd_en         (rd_en),
    .rd_valid      (rd_valid),
    .inc_i         (inc_i),
    .acc_flat      (acc_flat),
    .cache_flat    (cache_flat)
);

// File: tb/fec_stat_bank_tb.sv
module fec_stat_bank_tb;

    localparam int NUM  = 9;
    localparam int CW   = 16;
    localparam int IW   = 7;
    localparam int HW   = CW / 2;
    localparam int AW   = $clog2(NUM) + 1;
    localparam longint MAXV  = (64'd1 << CW) - 1;
    localparam longint HMASK = (64'd1 << HW) - 1;
    localparam longint IMASK = (64'd1 << IW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clear_on_snap = 1'b0;
    logic            snap_tick = 1'b0;
    logic [NUM*IW-1:0] inc_bus = '0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   rd_addr = '0;
    logic [HW-1:0]   rd_data;
    logic            rd_valid;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    started = 0;
    string cur_req = "R1";

    // reference model state
    longint m_acc [NUM];
    longint m_cache [NUM];
    longint m_hold;
    longint m_data;
    bit     m_valid;

    always #2 clk = ~clk;

    fec_stat_bank #(.NUM_CNT(NUM), .CNT_W(CW), .INC_W(IW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_on_snap (clear_on_snap),
        .snap_tick     (snap_tick),
        .inc_i         (inc_bus),
        .rd_en         (rd_en),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .rd_valid      (rd_valid)
    );

    // behavioural reference, advanced on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_acc[i]) begin
                m_acc[i] = 0;
                m_cache[i] = 0;
            end
            m_hold = 0; m_data = 0; m_valid = 0;
        end else begin
            started = 1;
            if (rd_en) begin
                longint idx, val;
                idx = longint'(rd_addr) >> 1;
                val = (idx < NUM) ? m_cache[idx] : 0;
                if (rd_addr[0]) begin
                    m_data = val >> HW;
                    m_hold = val & HMASK;
                end else begin
                    m_data = m_hold;
                end
            end
            m_valid = rd_en;
            for (int i = 0; i < NUM; i++) begin
                longint inc, sum, nxt;
                inc = longint'(inc_bus >> (i*IW)) & IMASK;
                sum = m_acc[i] + inc;
                if (clear_on_snap) nxt = snap_tick ? inc : (sum & MAXV);
                else               nxt = (sum > MAXV) ? MAXV : sum;
                if (snap_tick) m_cache[i] = m_acc[i];
                m_acc[i] = nxt;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (started || !rst_n) begin
            n_cmp++;
            if (rd_valid !== m_valid) begin
                n_bad++;
                $display("FAIL %s rd_valid actual=%0b expected=%0b t=%0t",
                         cur_req, rd_valid, m_valid, $time);
            end
            if (m_valid || !rst_n) begin
                n_cmp++;
                if (longint'(rd_data) !== m_data || $isunknown(rd_data)) begin
                    n_bad++;
                    $display("FAIL %s rd_data actual=%0h expected=%0h t=%0t",
                             cur_req, rd_data, m_data, $time);
                end
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(int addr);
        rd_en = 1'b1;
        rd_addr = AW'(addr);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_all();
        for (int i = 0; i < NUM; i++) begin
            rd(2*i + 1);
            rd(2*i);
        end
    endtask

    task automatic rand_inc();
        for (int i = 0; i < NUM; i++) inc_bus[i*IW +: IW] = IW'($urandom);
    endtask

    task automatic snap_pulse();
        snap_tick = 1'b1;
        @(negedge clk);
        snap_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state, then read the cleared cache
        cur_req = "R1";
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        read_all();

        // R2: counting without a strobe leaves the cache at zero
        cur_req = "R2";
        for (int k = 0; k < 50; k++) begin rand_inc(); cyc(1); end
        inc_bus = '0;
        read_all();

        // R3: snapshot copies the pre-increment accumulator values
        cur_req = "R3";
        snap_pulse();
        read_all();

        // R5: retain mode, strobe coinciding with increments
        cur_req = "R5";
        rand_inc();
        snap_pulse();
        for (int k = 0; k < 20; k++) begin rand_inc(); cyc(1); end
        snap_pulse();
        inc_bus = '0;
        read_all();

        // R4: clear mode with periodic strobes under traffic
        cur_req = "R4";
        clear_on_snap = 1'b1;
        for (int k = 0; k < 100; k++) begin
            rand_inc();
            if (k % 17 == 0) snap_tick = 1'b1;
            cyc(1);
            snap_tick = 1'b0;
        end
        rand_inc();
        snap_pulse();
        inc_bus = '0;
        read_all();

        // R8: snapshot between upper and lower read, lower via another index
        cur_req = "R8";
        rd(2*2 + 1);
        rand_inc();
        snap_pulse();
        inc_bus = '0;
        rd(2*5);
        rd(2*7 + 1);
        rd(2*7);

        // R6: saturation in retain mode
        cur_req = "R6";
        clear_on_snap = 1'b0;
        inc_bus = '1;
        cyc(600);
        snap_pulse();
        cyc(3);
        inc_bus = '0;
        snap_pulse();
        read_all();

        // R4: wrap in clear mode
        cur_req = "R4";
        clear_on_snap = 1'b1;
        snap_pulse();
        inc_bus = '1;
        cyc(600);
        snap_pulse();
        inc_bus = '0;
        read_all();

        // R7: indices beyond the bank read zero
        cur_req = "R7";
        for (int a = 2*NUM; a < (1 << AW); a++) rd(a);
        rd(1);
        cyc(1);
        rd(3);

        cyc(3);
        finish_run();
    end

endmodule